// File: doc/BRIEF.md
# Shadow register bank swapper

This block is a 32-entry integer register file in which a small, fixed group of registers has a second physical copy kept for privileged-mode code. Only registers 8 to 14 and register 25 have such a copy; every other register exists once. The live values always sit in the main array, so the read ports never need to know which mode is active. A mode change is done by physically exchanging each of the eight redirected registers with its shadow copy. The values that were live before the change are then held in the shadow bank until the next change brings them back.

A swap request carries the mode it moves to. A request whose target equals the mode already active is refused and flagged on an error output. The exchange is either done in one clock edge or stepped through the eight pairs over eight cycles, as chosen by a parameter. While a stepped swap runs, a busy output is high, and register writes and further swap requests are dropped. After reset the privileged copy is live, register 16 holds a CPU identifier taken from an input, and register 0 reads as zero whatever is written to it.

Top module: `shadow_swap_top`

## Requirements
- R1: While reset is held and in the first cycle after it, shadowMode is 1, busy is 0 and swapErr is 0. Register 16 reads the cpuId input value sampled during reset, and every other register reads 0.
- R2: Register 0 reads as 0 on both read ports at all times, and a write to address 0 has no visible effect.
- R3: Both read ports are combinational. An accepted write to a register other than 0 is visible on both ports in the cycle after the write edge.
- R4: An accepted swap exchanges each of registers 8, 9, 10, 11, 12, 13, 14 and 25 with its shadow copy. When the swap completes, each of these registers reads the value it had before the previous accepted swap (0 if there was none). Two successive swaps restore the original values.
- R5: A swap leaves all registers outside the set 8 to 14 and 25 unchanged, including the neighbours 7, 15, 24 and 26.
- R6: A swap request seen while not busy whose target mode (swapToShadow) equals shadowMode is illegal. swapErr is 1 for exactly the one cycle after that edge, no register is exchanged, and shadowMode does not change.
- R7: A legal swap request (not busy, target differs from shadowMode) sets shadowMode to the target value from the cycle after the request edge. shadowMode=1 means the privileged copy is live.
- R8: With SEQ_SWAP=1, busy is 1 for exactly 8 cycles after the edge that accepts a swap. With SEQ_SWAP=0, busy stays 0. A swap request while busy is ignored: it raises no error and does not change the mode.
- R9: A write is dropped when it is presented while busy is 1 or in the same cycle as an accepted swap request.
- R10: A write to a redirected register lands in the copy that is live at the time. After a swap it is hidden, and it reads back again after the next swap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpuId | input | DATA_W | Identifier loaded into register 16 at reset |
| rdAddrA | input | 5 | Read port A address |
| rdDataA | output | DATA_W | Read port A data |
| rdAddrB | input | 5 | Read port B address |
| rdDataB | output | DATA_W | Read port B data |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | 5 | Write address |
| wrData | input | DATA_W | Write data |
| swapReq | input | 1 | Swap request |
| swapToShadow | input | 1 | Target mode of the swap (1 = privileged copy live) |
| busy | output | 1 | Stepped swap in progress |
| swapErr | output | 1 | One-cycle flag for a redundant swap request |
| shadowMode | output | 1 | Currently live copy (1 = privileged) |

## Verification
The hardest situations to reach are the collisions around a stepped swap: a write or a second swap request arriving during the eight busy cycles, or a write in the very cycle a swap is accepted. A write in the acceptance cycle would race the exchange. The bench drives these collisions deliberately and then reads every register once busy drops, so that a dropped write shows up at the read ports. Redirected registers are seeded with distinct values in both modes before each swap, so a pair that is skipped or exchanged twice gives a wrong readback. A long random phase then mixes writes, legal and redundant swaps, and requests during busy, all against a behavioural model.

// File: rtl/shadow_swap_pkg.sv
package shadow_swap_pkg;
  localparam int ADDR_W     = 5;
  localparam int NUM_REGS   = 1 << ADDR_W;
  localparam int NUM_SHADOW = 8;
  localparam int STEP_W     = $clog2(NUM_SHADOW);

  typedef struct packed {
    logic              xchgAll;
    logic              xchgStep;
    logic [STEP_W-1:0] stepIdx;
    logic              wrAllow;
  } swapStrobe_t;

  // architectural register that owns shadow slot 'slot'
  function automatic logic [ADDR_W-1:0] shadowHome(input int unsigned slot);
    return (slot < 7) ? ADDR_W'(8 + slot) : ADDR_W'(25);
  endfunction

  function automatic logic isRedirected(input logic [ADDR_W-1:0] a);
    return ((a >= ADDR_W'(8)) && (a <= ADDR_W'(14))) || (a == ADDR_W'(25));
  endfunction
endpackage

// File: rtl/shadow_swap_ctrl.sv
module shadow_swap_ctrl
  import shadow_swap_pkg::*;
#(
  parameter bit SEQ_SWAP = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        swapReq,
  input  logic        swapToShadow,
  output swapStrobe_t strb,
  output logic        busy,
  output logic        swapErr,
  output logic        shadowMode
);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_SHADOW - 1);

  logic              modeQ;
  logic              errQ;
  logic              busyQ;
  logic [STEP_W-1:0] stepCnt;
  logic              accept;
  logic              illegal;

  assign accept  = swapReq && !busyQ && (swapToShadow != modeQ);
  assign illegal = swapReq && !busyQ && (swapToShadow == modeQ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      modeQ <= 1'b1;
      errQ  <= 1'b0;
    end else begin
      errQ <= illegal;
      if (accept) modeQ <= swapToShadow;
    end
  end

  generate
    if (SEQ_SWAP) begin : g_seq
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          busyQ   <= 1'b0;
          stepCnt <= '0;
        end else if (accept) begin
          busyQ   <= 1'b1;
          stepCnt <= '0;
        end else if (busyQ) begin
          if (stepCnt == LAST_STEP) busyQ <= 1'b0;
          stepCnt <= stepCnt + 1'b1;
        end
      end
      assign strb.xchgAll  = 1'b0;
      assign strb.xchgStep = busyQ;

      // R8: a stepped swap ends only after its last pair
      p_busy_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busyQ) |-> ($past(stepCnt) == LAST_STEP));
    end else begin : g_one
      assign busyQ         = 1'b0;
      assign stepCnt       = '0;
      assign strb.xchgAll  = accept;
      assign strb.xchgStep = 1'b0;
    end
  endgenerate

  assign strb.stepIdx = stepCnt;
  assign strb.wrAllow = !busyQ && !accept;

  assign busy       = busyQ;
  assign swapErr    = errQ;
  assign shadowMode = modeQ;

  p_illegal_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (swapReq && !busy && (swapToShadow == shadowMode)) |=>
      (swapErr && (shadowMode == $past(shadowMode))));

  p_mode_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (swapReq && !busy && (swapToShadow != shadowMode)) |=>
      (shadowMode == $past(swapToShadow)));

  p_busy_ignores_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!swapErr && (shadowMode == $past(shadowMode))));
endmodule

// File: rtl/shadow_swap_regs.sv
module shadow_swap_regs
  import shadow_swap_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] cpuId,
  input  swapStrobe_t       strb,
  input  logic [ADDR_W-1:0] rdAddrA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [ADDR_W-1:0] rdAddrB,
  output logic [DATA_W-1:0] rdDataB,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData
);
  logic [DATA_W-1:0] liveRegs   [NUM_REGS];
  logic [DATA_W-1:0] shadowRegs [NUM_SHADOW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NUM_REGS; r++) liveRegs[r] <= '0;
      for (int s = 0; s < NUM_SHADOW; s++) shadowRegs[s] <= '0;
      liveRegs[0]  <= cpuId;
      liveRegs[16] <= cpuId;
    end else begin
      for (int s = 0; s < NUM_SHADOW; s++) begin
        if (strb.xchgAll || (strb.xchgStep && (strb.stepIdx == STEP_W'(s)))) begin
          liveRegs[shadowHome(s)] <= shadowRegs[s];
          shadowRegs[s]           <= liveRegs[shadowHome(s)];
        end
      end
      if (strb.wrAllow && wrEn && (wrAddr != '0)) liveRegs[wrAddr] <= wrData;
    end
  end

  assign rdDataA = (rdAddrA == '0) ? '0 : liveRegs[rdAddrA];
  assign rdDataB = (rdAddrB == '0) ? '0 : liveRegs[rdAddrB];

  p_zero_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((rdAddrA == '0) |-> (rdDataA == '0)) and ((rdAddrB == '0) |-> (rdDataB == '0)));

  p_unshadowed_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.xchgAll || strb.xchgStep) |=>
      ((liveRegs[15] == $past(liveRegs[15])) && (liveRegs[24] == $past(liveRegs[24]))));

  p_last_pair_exchanged_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.xchgAll || (strb.xchgStep && (strb.stepIdx == STEP_W'(NUM_SHADOW - 1)))) |=>
      ((shadowRegs[NUM_SHADOW-1] == $past(liveRegs[25])) &&
       (liveRegs[25] == $past(shadowRegs[NUM_SHADOW-1]))));

  p_write_dropped_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb.wrAllow && wrEn && !isRedirected(wrAddr)) |=>
      (liveRegs[$past(wrAddr)] == $past(liveRegs[wrAddr])));
endmodule

// File: rtl/shadow_swap_top.sv
module shadow_swap_top
  import shadow_swap_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter bit SEQ_SWAP = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] cpuId,
  input  logic [ADDR_W-1:0] rdAddrA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [ADDR_W-1:0] rdAddrB,
  output logic [DATA_W-1:0] rdDataB,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              swapReq,
  input  logic              swapToShadow,
  output logic              busy,
  output logic              swapErr,
  output logic              shadowMode
);
  swapStrobe_t strb;

  shadow_swap_ctrl #(.SEQ_SWAP(SEQ_SWAP)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .swapReq(swapReq), .swapToShadow(swapToShadow),
    .strb(strb), .busy(busy), .swapErr(swapErr), .shadowMode(shadowMode)
  );

  shadow_swap_regs #(.DATA_W(DATA_W)) i_regs (
    .clk(clk), .rst_n(rst_n), .cpuId(cpuId), .strb(strb),
    .rdAddrA(rdAddrA), .rdDataA(rdDataA), .rdAddrB(rdAddrB), .rdDataB(rdDataB),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData)
  );
endmodule

// File: tb/test_shadow_swap_top.sv
module test_shadow_swap_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW         = 32;
  localparam bit SEQ        = 1'b1;
  localparam logic [DW-1:0] CPU_ID = 32'hC0DE_0005;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] cpuId = CPU_ID;
  logic [4:0]    rdAddrA = '0, rdAddrB = '0, wrAddr = '0;
  logic [DW-1:0] rdDataA, rdDataB, wrData = '0;
  logic          wrEn = 1'b0, swapReq = 1'b0, swapToShadow = 1'b0;
  logic          busy, swapErr, shadowMode;

  always #(CLK_PERIOD/2) clk = ~clk;

  shadow_swap_top #(.DATA_W(DW), .SEQ_SWAP(SEQ)) i_shadow_swap_top (
    .clk(clk), .rst_n(rst_n), .cpuId(cpuId),
    .rdAddrA(rdAddrA), .rdDataA(rdDataA), .rdAddrB(rdAddrB), .rdDataB(rdDataB),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .swapReq(swapReq), .swapToShadow(swapToShadow),
    .busy(busy), .swapErr(swapErr), .shadowMode(shadowMode)
  );

  // behavioural reference
  logic [DW-1:0] mLive [32];
  logic [DW-1:0] mSh   [8];
  int            homes [8] = '{8, 9, 10, 11, 12, 13, 14, 25};
  logic          mMode, mErr;
  int            mBusy;
  int            vectors = 0, miscompares = 0;
  string         curTag = "R1";
  bit            finished = 1'b0;

  function automatic bit redir(int a);
    foreach (homes[k]) if (homes[k] == a) return 1'b1;
    return 1'b0;
  endfunction

  task automatic modelReset();
    foreach (mLive[r]) mLive[r] = '0;
    foreach (mSh[s]) mSh[s] = '0;
    mLive[16] = CPU_ID;
    mMode = 1'b1; mErr = 1'b0; mBusy = 0;
  endtask

  task automatic modelEdge();
    bit idle, acc, ill;
    logic [DW-1:0] t;
    idle = (mBusy == 0);
    acc  = swapReq && idle && (swapToShadow != mMode);
    ill  = swapReq && idle && (swapToShadow == mMode);
    mErr = ill;
    if (wrEn && idle && !acc && wrAddr != 0) mLive[wrAddr] = wrData;
    if (acc) begin
      mMode = swapToShadow;
      foreach (homes[k]) begin t = mLive[homes[k]]; mLive[homes[k]] = mSh[k]; mSh[k] = t; end
      mBusy = SEQ ? 8 : 0;
    end else if (mBusy > 0) mBusy--;
  endtask

  task automatic cmp(string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%h expected=%h", curTag, what, act, exp);
    end
  endtask

  task automatic compareAll();
    cmp("busy", {31'b0, busy}, {31'b0, (mBusy > 0)});
    cmp("swapErr", {31'b0, swapErr}, {31'b0, mErr});
    cmp("shadowMode", {31'b0, shadowMode}, {31'b0, mMode});
    if (mBusy == 0 || !redir(rdAddrA))
      cmp($sformatf("rdDataA[%0d]", rdAddrA), rdDataA, (rdAddrA == 0) ? '0 : mLive[rdAddrA]);
    if (mBusy == 0 || !redir(rdAddrB))
      cmp($sformatf("rdDataB[%0d]", rdAddrB), rdDataB, (rdAddrB == 0) ? '0 : mLive[rdAddrB]);
  endtask

  // one clock: inputs set at negedge, model advanced at posedge, outputs checked at next negedge
  task automatic step(bit we, int wa, logic [DW-1:0] wd, bit sw, bit tg, int ra, int rb);
    wrEn = we; wrAddr = 5'(wa); wrData = wd; swapReq = sw; swapToShadow = tg;
    rdAddrA = 5'(ra); rdAddrB = 5'(rb);
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    compareAll();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, '0, 0, 0, i % 32, (i + 16) % 32);
  endtask

  task automatic readAll();
    for (int r = 0; r < 16; r++) step(0, 0, '0, 0, 0, r, r + 16);
  endtask

  task automatic waitIdle();
    int guard = 0;
    while (mBusy > 0 && guard < 20) begin idle(1); guard++; end
  endtask

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    curTag = "R1";
    compareAll();
    rst_n = 1'b1;
    @(negedge clk);
    compareAll();
    readAll();

    curTag = "R3";
    for (int r = 1; r < 32; r++) step(1, r, 32'h1000_0000 + r * 32'h0101, 0, 0, r, 31 - r);
    readAll();

    curTag = "R2";
    step(1, 0, 32'hFFFF_FFFF, 0, 0, 0, 0);
    step(0, 0, '0, 0, 0, 0, 16);

    curTag = "R7";
    step(0, 0, '0, 1, 0, 8, 25);
    curTag = "R4";
    waitIdle();
    readAll();
    curTag = "R10";
    foreach (homes[k]) step(1, homes[k], 32'hB0B0_0000 + k, 0, 0, homes[k], 7);
    step(0, 0, '0, 1, 1, 25, 15);
    waitIdle();
    curTag = "R4";
    readAll();
    step(0, 0, '0, 1, 0, 9, 24);
    waitIdle();
    curTag = "R10";
    readAll();
    curTag = "R5";
    step(0, 0, '0, 0, 0, 7, 15);
    step(0, 0, '0, 0, 0, 24, 26);

    curTag = "R6";
    step(0, 0, '0, 1, 0, 8, 16);
    step(0, 0, '0, 0, 0, 8, 16);
    step(0, 0, '0, 1, 0, 25, 3);

    curTag = "R9";
    step(1, 3, 32'hDEAD_0003, 1, 1, 3, 8);
    step(1, 4, 32'hDEAD_0004, 0, 0, 4, 3);
    curTag = "R8";
    step(0, 0, '0, 1, 0, 4, 5);
    step(1, 10, 32'hDEAD_000A, 1, 1, 10, 5);
    waitIdle();
    curTag = "R9";
    readAll();

    curTag = "R3";
    for (int i = 0; i < 3000; i++) begin
      int u = $urandom;
      step((u & 1) == 1, (u >> 1) & 31, $urandom, ((u >> 6) & 7) == 0, ((u >> 9) & 1) == 1,
           (u >> 10) & 31, (u >> 15) & 31);
    end
    waitIdle();
    curTag = "R4";
    readAll();

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      miscompares++;
      $display("FAIL R8 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule